// File: doc/BRIEF.md
# Register-Mapped Serial Port with Queues

This block is a UART that a processor drives through a small 32-bit register bus. Software queues outgoing bytes by writing a data register and collects incoming bytes by reading another one. Each of these two data registers also carries the queue status in bit 31. On the transmit side, bit 31 reads back as one when the queue is full. On the receive side, bit 31 reads back as one when the queue is empty. A single read of the receive register therefore takes a byte out of the queue and reports emptiness at the same moment.

The line format is one start bit, eight data bits sent least significant bit first, no parity and one stop bit. Every bit lasts `div + 1` input clocks, so a divisor of zero sends one bit per clock. Each direction has its own enable bit and its own watermark count. The two watermark comparisons drive a pending register. An enable mask gates the pending register onto a single interrupt line.

Software sets the divisor first, then enables the directions it needs, then writes and reads bytes. It can either poll bit 31 of the data registers or use the watermark interrupt.

Top module: `mmio_uart`

## Requirements
- R1: After reset, every control register, the enable mask and the divisor read as 0. The receive data register reads 0x8000_0000. The transmit data register reads 0. `ser_tx` is high and `irq` is low.
- R2: A write to the transmit data register (byte offset 0x00) queues bits 7:0. A read of that register returns bit 31 set exactly when the transmit queue holds 8 entries. A write while the queue is full is dropped and leaves the queued bytes unchanged.
- R3: A read of the receive data register (offset 0x04) behaves as follows. If the receive queue is empty, the read returns bit 31 set with all other bits zero and changes nothing. Otherwise the read returns the oldest byte in bits 7:0 with bit 31 clear, and removes that byte from the queue.
- R4: A transmitted frame has these parts, each held for exactly `div + 1` clocks, where `div` is the register at offset 0x18: a low start bit, then data bits 0 through 7, then a high stop bit.
- R5: Bit 0 of the transmit control register (offset 0x08) enables sending. While it is 0, no new frame starts and `ser_tx` stays high.
- R6: When bit 0 of the receive control register (offset 0x0C) is set, the receiver samples each bit at its middle and queues every well-formed frame at any divisor. While the bit is 0, frames on `ser_rx` are ignored.
- R7: A frame whose stop bit samples low is discarded. The receiver then waits for the line to return high before it looks for another start bit.
- R8: Pending bit 0 (register at offset 0x14) is set when the transmit occupancy is below transmit control bits 18:16. Pending bit 1 is set when the receive occupancy is above receive control bits 18:16.
- R9: `irq` is the OR over the bits of pending AND enable mask (offset 0x10, bits 1:0). An enable mask of 0 holds `irq` low.
- R10: Both queues hold 8 entries each and deliver bytes in first-in first-out order.
- R11: The divisor register holds 16 bits and reads back exactly what was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address; bits 4:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| ser_tx | output | 1 | Serial transmit line, idle high |
| ser_rx | input | 1 | Serial receive line, idle high |
| irq | output | 1 | Interrupt request |

## Verification
The main check loops the transmit line back into the receiver. At divisor 0 it sends all 256 byte values. Any single data bit that is stuck, swapped or off by one sample shows up as a wrong received value. At divisors 1, 2 and 7 it sends the all-zero, all-one and alternating patterns. These tell apart an off-by-one bit period and an early or late middle sample, both of which only appear when a bit spans several clocks.

The transmit line is also measured directly: the start-bit width and the middle-of-bit values are checked against `div + 1`. Frames driven by hand with a low stop bit, and frames sent while the receiver is disabled, must leave the receive queue empty.

// File: rtl/uart_pkg.sv
// Package: shared register indices and field positions of the serial port.
// Assumes word-aligned accesses; the index is the byte address divided by 4.
package uart_pkg;
    typedef enum logic [2:0] {
        IDX_TXDATA = 3'd0,
        IDX_RXDATA = 3'd1,
        IDX_TXCTRL = 3'd2,
        IDX_RXCTRL = 3'd3,
        IDX_IE     = 3'd4,
        IDX_IP     = 3'd5,
        IDX_DIV    = 3'd6
    } reg_idx_e;

    localparam int STAT_BIT = 31;
    localparam int WM_LSB   = 16;
    localparam int WM_W     = 3;
    localparam int FRAME_W  = 10;
endpackage

// File: rtl/uart_fifo.sv
// Module: synchronous first-in first-out queue with occupancy count.
// Assumes push is ignored when full and pop is ignored when empty;
// the head entry is presented combinationally on rd_data.
module uart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  wr_data,
    input  logic          pop_i,
    output logic [W-1:0]  rd_data,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          empty_o
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          do_push, do_pop;

    assign full_o  = (count == CW'(DEPTH));
    assign empty_o = (count == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign rd_data = mem[rd_ptr];
    assign count_o = count;

    // Storage write at the tail pointer.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr_data;
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R2: a push into a full queue with no pop leaves occupancy unchanged
    a_r2_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (full_o && push_i && !pop_i) |=> $stable(count_o));
    // R3: popping an empty queue without a push keeps it empty
    a_r3_empty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (empty_o && pop_i && !push_i) |=> empty_o);
    // R10: occupancy never exceeds the depth
    a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        count_o <= CW'(DEPTH));
endmodule

// File: rtl/uart_tx.sv
// Module: transmit shifter. Pops one byte per frame from the queue and
// sends start, eight data bits LSB first and stop, each div_i+1 clocks.
// Assumes div_i is steady while a frame is in flight.
module uart_tx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             empty_i,
    input  logic [7:0]       data_i,
    output logic             pop_o,
    output logic             txd_o
);
    import uart_pkg::*;
    localparam int BCW = $clog2(FRAME_W + 1);

    logic               busy;
    logic [FRAME_W-1:0] shreg;
    logic [BCW-1:0]     bits_left;
    logic [DIV_W-1:0]   cnt;

    assign pop_o = !busy && en_i && !empty_i;
    assign txd_o = busy ? shreg[0] : 1'b1;

    // Frame sequencer: load on start, shift once per bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            shreg     <= '1;
            bits_left <= '0;
            cnt       <= '0;
        end else if (pop_o) begin
            busy      <= 1'b1;
            shreg     <= {1'b1, data_i, 1'b0};
            bits_left <= BCW'(FRAME_W);
            cnt       <= '0;
        end else if (busy) begin
            if (cnt == div_i) begin
                cnt       <= '0;
                shreg     <= {1'b1, shreg[FRAME_W-1:1]};
                bits_left <= bits_left - 1'b1;
                if (bits_left == BCW'(1)) busy <= 1'b0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R5: an idle, disabled transmitter stays idle
    a_r5_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !en_i) |=> (!busy && txd_o));
endmodule

// File: rtl/uart_rx.sv
// Module: receive sampler. Synchronises the line, checks the start bit at
// its middle, samples eight data bits and the stop bit one period apart.
// Assumes div_i is steady while a frame is in flight.
module uart_rx #(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic [DIV_W-1:0] div_i,
    input  logic             rxd_i,
    output logic             push_o,
    output logic [7:0]       data_o
);
    typedef enum logic [2:0] {R_IDLE, R_START, R_DATA, R_STOP, R_WAIT} rx_st_e;

    rx_st_e           st;
    logic [1:0]       sync;
    logic             line;
    logic [DIV_W-1:0] cnt;
    logic [DIV_W-1:0] half;
    logic [2:0]       bitn;
    logic [7:0]       shreg;

    assign line   = sync[1];
    assign half   = div_i >> 1;
    assign data_o = shreg;

    // Two-flop synchroniser on the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync <= 2'b11;
        else        sync <= {sync[0], rxd_i};
    end

    // Frame state machine with middle-of-bit sampling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= R_IDLE;
            cnt    <= '0;
            bitn   <= '0;
            shreg  <= '0;
            push_o <= 1'b0;
        end else begin
            push_o <= 1'b0;
            case (st)
                R_IDLE: begin
                    if (en_i && !line) begin
                        bitn <= '0;
                        if (half == '0) begin
                            st  <= R_DATA;
                            cnt <= '0;
                        end else begin
                            st  <= R_START;
                            cnt <= DIV_W'(1);
                        end
                    end
                end
                R_START: begin
                    if (cnt == half) begin
                        cnt <= '0;
                        st  <= line ? R_IDLE : R_DATA;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                R_DATA: begin
                    if (cnt == div_i) begin
                        cnt   <= '0;
                        shreg <= {line, shreg[7:1]};
                        bitn  <= bitn + 1'b1;
                        if (bitn == 3'd7) st <= R_STOP;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                R_STOP: begin
                    if (cnt == div_i) begin
                        cnt <= '0;
                        if (line) begin
                            push_o <= 1'b1;
                            st     <= R_IDLE;
                        end else begin
                            st <= R_WAIT;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                R_WAIT: begin
                    if (line) st <= R_IDLE;
                end
                default: st <= R_IDLE;
            endcase
        end
    end

    // R7: a byte is only queued after a high stop-bit sample
    a_r7_push_needs_stop: assert property (@(posedge clk) disable iff (!rst_n)
        push_o |-> $past(line));
endmodule

// File: rtl/mmio_uart.sv
// Module: top of the register-mapped serial port. Decodes the 32-bit
// register bus, holds the control state, connects the two queues to the
// shifter and the sampler, and forms pending bits and the interrupt.
// Assumes single-cycle accesses; read data is combinational from bus_addr.
module mmio_uart #(
    parameter int DEPTH = 8,
    parameter int DIV_W = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        ser_tx,
    input  logic        ser_rx,
    output logic        irq
);
    import uart_pkg::*;

    reg_idx_e         idx;
    logic             wr_stb, rd_stb;
    logic             tx_en, rx_en;
    logic [WM_W-1:0]  tx_wm, rx_wm;
    logic [1:0]       ie_q, ip;
    logic [DIV_W-1:0] div_q;

    logic             tq_push, tq_pop, tq_full, tq_empty;
    logic [7:0]       tq_head;
    logic [CW-1:0]    tq_cnt;
    logic             rq_push, rq_pop, rq_full, rq_empty;
    logic [7:0]       rq_head, rx_byte;
    logic [CW-1:0]    rq_cnt;
    logic             unused_bits;

    assign idx         = reg_idx_e'(bus_addr[4:2]);
    assign wr_stb      = bus_sel && bus_wr;
    assign rd_stb      = bus_sel && !bus_wr;
    assign tq_push     = wr_stb && (idx == IDX_TXDATA);
    assign rq_pop      = rd_stb && (idx == IDX_RXDATA);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata, rq_full};

    // Control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en <= 1'b0;
            rx_en <= 1'b0;
            tx_wm <= '0;
            rx_wm <= '0;
            ie_q  <= '0;
            div_q <= '0;
        end else if (wr_stb) begin
            case (idx)
                IDX_TXCTRL: begin
                    tx_en <= bus_wdata[0];
                    tx_wm <= bus_wdata[WM_LSB +: WM_W];
                end
                IDX_RXCTRL: begin
                    rx_en <= bus_wdata[0];
                    rx_wm <= bus_wdata[WM_LSB +: WM_W];
                end
                IDX_IE:  ie_q  <= bus_wdata[1:0];
                IDX_DIV: div_q <= bus_wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end

    // Watermark pending flags and interrupt combine.
    always_comb begin
        ip[0] = (tq_cnt < CW'(tx_wm));
        ip[1] = (rq_cnt > CW'(rx_wm));
        irq   = |(ip & ie_q);
    end

    // Read data multiplexer.
    always_comb begin
        bus_rdata = '0;
        case (idx)
            IDX_TXDATA: bus_rdata[STAT_BIT] = tq_full;
            IDX_RXDATA: begin
                bus_rdata[STAT_BIT] = rq_empty;
                if (!rq_empty) bus_rdata[7:0] = rq_head;
            end
            IDX_TXCTRL: begin
                bus_rdata[0]               = tx_en;
                bus_rdata[WM_LSB +: WM_W]  = tx_wm;
            end
            IDX_RXCTRL: begin
                bus_rdata[0]               = rx_en;
                bus_rdata[WM_LSB +: WM_W]  = rx_wm;
            end
            IDX_IE:  bus_rdata[1:0] = ie_q;
            IDX_IP:  bus_rdata[1:0] = ip;
            IDX_DIV: bus_rdata[DIV_W-1:0] = div_q;
            default: bus_rdata = '0;
        endcase
    end

    uart_fifo #(.W(8), .DEPTH(DEPTH)) tx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(tq_push), .wr_data(bus_wdata[7:0]),
        .pop_i(tq_pop), .rd_data(tq_head),
        .count_o(tq_cnt), .full_o(tq_full), .empty_o(tq_empty)
    );

    uart_fifo #(.W(8), .DEPTH(DEPTH)) rx_q_i (
        .clk(clk), .rst_n(rst_n),
        .push_i(rq_push), .wr_data(rx_byte),
        .pop_i(rq_pop), .rd_data(rq_head),
        .count_o(rq_cnt), .full_o(rq_full), .empty_o(rq_empty)
    );

    uart_tx #(.DIV_W(DIV_W)) tx_i (
        .clk(clk), .rst_n(rst_n),
        .en_i(tx_en), .div_i(div_q),
        .empty_i(tq_empty), .data_i(tq_head),
        .pop_o(tq_pop), .txd_o(ser_tx)
    );

    uart_rx #(.DIV_W(DIV_W)) rx_i (
        .clk(clk), .rst_n(rst_n),
        .en_i(rx_en), .div_i(div_q), .rxd_i(ser_rx),
        .push_o(rq_push), .data_o(rx_byte)
    );

    // R9: a zero enable mask keeps the interrupt low
    a_r9_irq_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (ie_q == 2'b00) |-> !irq);
    // R8: an empty receive queue never raises the receive watermark flag
    a_r8_rx_wm_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_cnt == '0) |-> !ip[1]);
endmodule

// File: tb/mmio_uart_tb.sv
module mmio_uart_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ser_tx, irq;
    logic        loop = 1'b0, rxd_drv = 1'b1;
    logic        ser_rx;
    int          n_chk = 0, n_fail = 0;

    assign ser_rx = loop ? ser_tx : rxd_drv;
    always #5 clk = ~clk;

    mmio_uart dut_i (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ser_tx(ser_tx), .ser_rx(ser_rx), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Capture one frame from ser_tx; valid for bytes with bit 0 set.
    task automatic capture(input int dv, output logic [7:0] b, output int slen, output logic stopb);
        int guard = 0;
        slen = 0;
        @(negedge clk);
        while (ser_tx !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
        while (ser_tx === 1'b0 && slen < 5000) begin slen++; @(negedge clk); end
        repeat (dv / 2) @(negedge clk);
        b[0] = ser_tx;
        for (int i = 1; i < 8; i++) begin
            repeat (dv + 1) @(negedge clk);
            b[i] = ser_tx;
        end
        repeat (dv + 1) @(negedge clk);
        stopb = ser_tx;
    endtask

    // Drive one frame on the receive line from the bench.
    task automatic send(input logic [7:0] b, input logic stopb, input int dv);
        logic [9:0] fr;
        fr = {stopb, b, 1'b0};
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); rxd_drv = fr[i];
            repeat (dv) @(negedge clk);
        end
        @(negedge clk); rxd_drv = 1'b1;
        repeat (2 * (dv + 1) + 4) @(negedge clk);
    endtask

    initial begin : watchdog
        #(200000 * 10);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] d;
        logic [7:0]  b;
        int          slen;
        logic        stopb;
        int          dvs[3];
        logic [7:0]  pats[4];
        int          lows;

        dvs = '{1, 2, 7};
        pats = '{8'h00, 8'hFF, 8'h5A, 8'h81};
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 txd idle", {31'b0, ser_tx}, 32'd1);
        check("R1 irq low", {31'b0, irq}, 32'd0);
        rd(5'h00, d); check("R1 txdata", d, 32'h0);
        rd(5'h04, d); check("R1 rxdata empty", d, 32'h8000_0000);
        for (int a = 2; a < 7; a++) begin
            rd(5'(a * 4), d); check("R1 ctrl zero", d, 32'h0);
        end

        // R11 divisor readback
        wr(5'h18, 32'h0000_BEEF); rd(5'h18, d); check("R11 div", d, 32'h0000_BEEF);
        wr(5'h18, 32'hFFFF_1234); rd(5'h18, d); check("R11 div width", d, 32'h0000_1234);

        // R4 frame timing at two divisors
        for (int k = 0; k < 2; k++) begin
            int dv;
            dv = (k == 0) ? 0 : 3;
            wr(5'h18, 32'(dv));
            wr(5'h08, 32'h1);
            wr(5'h00, 32'hA5);
            capture(dv, b, slen, stopb);
            check("R4 start width", 32'(slen), 32'(dv + 1));
            check("R4 data bits", {24'b0, b}, 32'hA5);
            check("R4 stop bit", {31'b0, stopb}, 32'd1);
            idle(4 * (dv + 1));
        end

        // R5 transmitter disabled holds the line
        wr(5'h08, 32'h0);
        wr(5'h00, 32'h3B);
        lows = 0;
        for (int i = 0; i < 100; i++) begin @(negedge clk); if (ser_tx !== 1'b1) lows++; end
        check("R5 no frame while disabled", 32'(lows), 32'd0);
        wr(5'h08, 32'h1);
        capture(3, b, slen, stopb);
        check("R5 frame after enable", {24'b0, b}, 32'h3B);
        idle(10);

        // R6 loopback sweep: all bytes at div 0
        loop = 1'b1;
        wr(5'h18, 32'h0);
        wr(5'h0C, 32'h1);
        for (int v = 0; v < 256; v++) begin
            wr(5'h00, 32'(v));
            idle(16);
            rd(5'h04, d);
            check("R6 loopback div0", d, 32'(v));
        end
        // R6 patterns at several divisors
        foreach (dvs[j]) begin
            wr(5'h18, 32'(dvs[j]));
            foreach (pats[p]) begin
                wr(5'h00, {24'b0, pats[p]});
                idle(12 * (dvs[j] + 1) + 8);
                rd(5'h04, d);
                check("R6 loopback pattern", d, {24'b0, pats[p]});
            end
        end

        // R2 / R10 queue depth, full flag, drop and order
        wr(5'h18, 32'h0);
        wr(5'h08, 32'h0);
        for (int i = 0; i < 7; i++) wr(5'h00, 32'h10 + 32'(i));
        rd(5'h00, d); check("R2 not full at 7", d, 32'h0);
        wr(5'h00, 32'h17);
        rd(5'h00, d); check("R2 full at 8", d, 32'h8000_0000);
        wr(5'h00, 32'hEE);
        wr(5'h08, 32'h1);
        idle(8 * 16);
        for (int i = 0; i < 8; i++) begin
            rd(5'h04, d); check("R10 fifo order", d, 32'h10 + 32'(i));
        end
        rd(5'h04, d); check("R2 dropped write absent", d, 32'h8000_0000);

        // R3 empty read changes nothing
        rd(5'h04, d); check("R3 empty read", d, 32'h8000_0000);
        wr(5'h00, 32'h6C);
        idle(16);
        rd(5'h04, d); check("R3 pop byte", d, 32'h6C);
        rd(5'h04, d); check("R3 empty after pop", d, 32'h8000_0000);

        // R7 bad stop bit, R6 bench-driven frame and disabled receiver
        loop = 1'b0;
        wr(5'h18, 32'd3);
        send(8'h3C, 1'b0, 3);
        rd(5'h04, d); check("R7 bad stop dropped", d, 32'h8000_0000);
        send(8'hC3, 1'b1, 3);
        rd(5'h04, d); check("R6 driven frame", d, 32'hC3);
        wr(5'h0C, 32'h0);
        send(8'h55, 1'b1, 3);
        rd(5'h04, d); check("R6 disabled receiver", d, 32'h8000_0000);

        // R8 / R9 watermark flags and interrupt mask
        wr(5'h08, 32'h0001_0000);
        rd(5'h14, d); check("R8 tx wm set", d, 32'h1);
        check("R9 masked", {31'b0, irq}, 32'd0);
        wr(5'h10, 32'h1);
        @(negedge clk); check("R9 tx irq", {31'b0, irq}, 32'd1);
        wr(5'h08, 32'h0000_0001);
        rd(5'h14, d); check("R8 tx wm clear", d, 32'h0);
        check("R9 irq clear", {31'b0, irq}, 32'd0);
        loop = 1'b1;
        wr(5'h18, 32'h0);
        wr(5'h0C, 32'h0001_0001);
        wr(5'h00, 32'h41);
        idle(16);
        rd(5'h14, d); check("R8 rx wm one entry", d, 32'h0);
        wr(5'h00, 32'h42);
        idle(16);
        rd(5'h14, d); check("R8 rx wm above", d, 32'h2);
        check("R9 rx masked by ie", {31'b0, irq}, 32'd0);
        wr(5'h10, 32'h2);
        @(negedge clk); check("R9 rx irq", {31'b0, irq}, 32'd1);
        wr(5'h10, 32'h0);
        @(negedge clk); check("R9 ie zero", {31'b0, irq}, 32'd0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule